// File: doc/BRIEF.md
# Return-Stall Front-End Controller

This block steers the front of a five-stage in-order pipeline around subroutine returns. A return instruction gets its target address from data memory, and that value only appears in the writeback-stage register bank. Until it arrives, the fetch stage cannot know where to go next. The block detects a return anywhere between decode and memory. While one is there, it freezes the fetch-stage register, which holds the predicted next address, and it injects a no-operation into the decode register each cycle.

When the return reaches writeback, no more freezing is needed. The fetch address is then taken from the writeback memory value instead of the prediction. A plain memory load in writeback also carries a memory value, but it never steers fetch.

The block contains the fetch register and the decode register, which holds the instruction code and the two destination register identifiers. It takes the execute, memory and writeback instruction codes from the rest of the pipeline. The fetch decoder supplies the predicted next address and the fields of the fetched instruction.

Top module: `ret_front_ctl`

## Requirements
- R1: After reset, `fetch_pc` is 0 (with a non-return code in writeback), `d_icode` is the no-operation code 4'h1, and both `d_dst_e` and `d_dst_m` are the no-register code 4'hF.
- R2: `stall_f` and `bubble_d` are both 1 in any cycle where `d_icode`, `e_icode` or `m_icode` equals the return code 4'h9.
- R3: A return code in `w_icode` alone, with no return code in decode, execute or memory, leaves `stall_f` and `bubble_d` at 0.
- R4: While `stall_f` is 1, the fetch register keeps its value across the clock edge. The next cycle's `fetch_pc` therefore equals the current one when writeback holds no return.
- R5: After an edge with `bubble_d` at 1, `d_icode` is 4'h1 and both destination outputs are 4'hF, whatever the fetch inputs were.
- R6: When `w_icode` is 4'h9, `fetch_pc` equals `w_valm` in the same cycle. Otherwise it equals the fetch register, which holds the last loaded `fetch_pred_pc`.
- R7: A load code 4'h5 (or any other non-return code) in `w_icode` never routes `w_valm` to `fetch_pc`.
- R8: With no hazard, each edge loads `fetch_pred_pc` into the fetch register and loads `fetch_icode`, `fetch_dst_e` and `fetch_dst_m` into the decode register.
- R9: Consider a return fetched in cycle N, with the later stage codes fed from the decode output one stage per cycle. Cycles N+1 to N+3 are stalled and keep the fetch address that follows the return. Cycle N+4 fetches from the return target, and cycle N+5 fetches from the target plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pred_pc | input | PC_W | Predicted next address from the fetch decoder |
| fetch_icode | input | 4 | Instruction code of the fetched instruction |
| fetch_dst_e | input | 4 | ALU-result destination register of the fetched instruction |
| fetch_dst_m | input | 4 | Memory-result destination register of the fetched instruction |
| e_icode | input | 4 | Instruction code held in the execute register |
| m_icode | input | 4 | Instruction code held in the memory register |
| w_icode | input | 4 | Instruction code held in the writeback register |
| w_valm | input | PC_W | Memory value held in the writeback register |
| fetch_pc | output | PC_W | Address to fetch from this cycle |
| stall_f | output | 1 | Fetch register hold |
| bubble_d | output | 1 | Decode register no-operation injection |
| d_icode | output | 4 | Instruction code in the decode register |
| d_dst_e | output | 4 | ALU destination in the decode register |
| d_dst_m | output | 4 | Memory destination in the decode register |

## Verification
The assertions check the following on every cycle:
- a return in decode always stalls;
- a lone return in writeback never stalls;
- a stalled fetch register holds its value;
- a bubbled decode register carries the no-operation contents;
- a return in writeback redirects the fetch address, and a load in writeback does not.

Only the bench's scenarios can show the full cycle timeline of a return moving down the pipeline, which needs a model of the later stages outside the block. The scenarios also show the reset values and that unhazarded fetch fields reach the decode register intact.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int ICODE_W = 4;
  localparam int REG_W   = 4;

  typedef logic [ICODE_W-1:0] icode_t;
  typedef logic [REG_W-1:0]   regid_t;

  localparam icode_t IC_NOP  = 4'h1;
  localparam icode_t IC_LOAD = 4'h5;
  localparam icode_t IC_RET  = 4'h9;
  localparam regid_t REG_NONE = 4'hF;

  function automatic logic is_ret(input icode_t c);
    return c == IC_RET;
  endfunction
endpackage

// File: rtl/ret_hazard_unit.sv
module ret_hazard_unit
  import fe_pkg::*;
#(
  parameter int N_WATCH = 3
) (
  input  icode_t watch_icode [N_WATCH],
  output logic   hazard,
  output logic   stall_f,
  output logic   bubble_d
);
  logic [N_WATCH-1:0] stage_hit;

  for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
    assign stage_hit[g] = is_ret(watch_icode[g]);
  end

  assign hazard   = |stage_hit;
  assign stall_f  = hazard;
  assign bubble_d = hazard;
endmodule

// File: rtl/fetch_pc_mux.sv
module fetch_pc_mux
  import fe_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  icode_t          w_icode,
  input  logic [PC_W-1:0] w_valm,
  input  logic [PC_W-1:0] pred_q,
  output logic            redirect,
  output logic [PC_W-1:0] fetch_pc
);
  function automatic logic [PC_W-1:0] pick_pc(input logic sel_mem,
                                              input logic [PC_W-1:0] mem_val,
                                              input logic [PC_W-1:0] pred);
    return sel_mem ? mem_val : pred;
  endfunction

  assign redirect = is_ret(w_icode);
  assign fetch_pc = pick_pc(redirect, w_valm, pred_q);
endmodule

// File: rtl/front_regs.sv
module front_regs
  import fe_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall_f,
  input  logic            bubble_d,
  input  logic [PC_W-1:0] pred_in,
  input  icode_t          icode_in,
  input  regid_t          dst_e_in,
  input  regid_t          dst_m_in,
  output logic [PC_W-1:0] pred_q,
  output icode_t          d_icode,
  output regid_t          d_dst_e,
  output regid_t          d_dst_m
);
  always_ff @(posedge clk) begin
    if (!rst_n)        pred_q <= '0;
    else if (!stall_f) pred_q <= pred_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bubble_d) begin
      d_icode <= IC_NOP;
      d_dst_e <= REG_NONE;
      d_dst_m <= REG_NONE;
    end else begin
      d_icode <= icode_in;
      d_dst_e <= dst_e_in;
      d_dst_m <= dst_m_in;
    end
  end

  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_f |=> pred_q == $past(pred_q));

  p_bubble_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_d |=> (d_icode == IC_NOP && d_dst_e == REG_NONE && d_dst_m == REG_NONE));
endmodule

// File: rtl/ret_front_ctl.sv
module ret_front_ctl
  import fe_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pred_pc,
  input  logic [3:0]      fetch_icode,
  input  logic [3:0]      fetch_dst_e,
  input  logic [3:0]      fetch_dst_m,
  input  logic [3:0]      e_icode,
  input  logic [3:0]      m_icode,
  input  logic [3:0]      w_icode,
  input  logic [PC_W-1:0] w_valm,
  output logic [PC_W-1:0] fetch_pc,
  output logic            stall_f,
  output logic            bubble_d,
  output logic [3:0]      d_icode,
  output logic [3:0]      d_dst_e,
  output logic [3:0]      d_dst_m
);
  localparam int N_WATCH = 3;

  logic [PC_W-1:0] pred_q;
  logic            hazard;
  logic            redirect;
  icode_t          watch [N_WATCH];

  assign watch[0] = d_icode;
  assign watch[1] = e_icode;
  assign watch[2] = m_icode;

  ret_hazard_unit #(.N_WATCH(N_WATCH)) u_hazard (
    .watch_icode (watch),
    .hazard      (hazard),
    .stall_f     (stall_f),
    .bubble_d    (bubble_d)
  );

  fetch_pc_mux #(.PC_W(PC_W)) u_pcmux (
    .w_icode  (w_icode),
    .w_valm   (w_valm),
    .pred_q   (pred_q),
    .redirect (redirect),
    .fetch_pc (fetch_pc)
  );

  front_regs #(.PC_W(PC_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall_f  (stall_f),
    .bubble_d (bubble_d),
    .pred_in  (fetch_pred_pc),
    .icode_in (fetch_icode),
    .dst_e_in (fetch_dst_e),
    .dst_m_in (fetch_dst_m),
    .pred_q   (pred_q),
    .d_icode  (d_icode),
    .d_dst_e  (d_dst_e),
    .d_dst_m  (d_dst_m)
  );

  p_ret_in_d_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (d_icode == IC_RET) |-> (stall_f && bubble_d));

  p_w_ret_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_icode == IC_RET && d_icode != IC_RET && e_icode != IC_RET && m_icode != IC_RET)
      |-> (!stall_f && !bubble_d));

  p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (w_icode == IC_RET) |-> (fetch_pc == w_valm));

  p_load_no_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_icode == IC_LOAD) |-> (fetch_pc == pred_q && !redirect));

  p_hazard_consistent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> (stall_f && bubble_d));
endmodule

// File: tb/test_ret_front_ctl.sv
module test_ret_front_ctl;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] fetch_pred_pc = '0;
  logic [3:0]      fetch_icode = 4'h1, fetch_dst_e = 4'hF, fetch_dst_m = 4'hF;
  logic [3:0]      e_icode = 4'h1, m_icode = 4'h1, w_icode = 4'h1;
  logic [PC_W-1:0] w_valm = '0;
  logic [PC_W-1:0] fetch_pc;
  logic            stall_f, bubble_d;
  logic [3:0]      d_icode, d_dst_e, d_dst_m;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  ret_front_ctl #(.PC_W(PC_W)) i_ret_front_ctl (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_later(input logic [3:0] e, input logic [3:0] m, input logic [3:0] w, input logic [31:0] vm);
    e_icode = e; m_icode = m; w_icode = w; w_valm = vm;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_later(4'h1, 4'h1, 4'h1, 32'h0);
    fetch_pred_pc = 32'h1234; fetch_icode = 4'h2; fetch_dst_e = 4'h3; fetch_dst_m = 4'h4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(fetch_pc == 0, "R1 pc", fetch_pc, 0);
    chk(d_icode == 4'h1, "R1 d_icode", d_icode, 4'h1);
    chk(d_dst_e == 4'hF && d_dst_m == 4'hF, "R1 dst", {d_dst_e, d_dst_m}, 8'hFF);
    chk(!stall_f && !bubble_d, "R1 no stall", {stall_f, bubble_d}, 0);
  endtask

  task automatic t_load_path();
    do_reset();
    fetch_pred_pc = 32'h10; fetch_icode = 4'h6; fetch_dst_e = 4'h2; fetch_dst_m = 4'hF;
    @(negedge clk); #1;
    chk(fetch_pc == 32'h10, "R8 pc loaded", fetch_pc, 32'h10);
    chk(d_icode == 4'h6 && d_dst_e == 4'h2 && d_dst_m == 4'hF, "R8 D loaded",
        {d_icode, d_dst_e, d_dst_m}, 12'h62F);
    fetch_icode = 4'h2;
    set_later(4'h1, 4'h1, 4'h5, 32'hDEAD_BEEF);
    #1;
    chk(fetch_pc == 32'h10, "R7 load in W", fetch_pc, 32'h10);
    set_later(4'h1, 4'h1, 4'h9, 32'hDEAD_BEEF);
    #1;
    chk(fetch_pc == 32'hDEAD_BEEF, "R6 ret in W", fetch_pc, 32'hDEAD_BEEF);
    chk(!stall_f && !bubble_d, "R3 ret in W only", {stall_f, bubble_d}, 0);
    set_later(4'h1, 4'h1, 4'h1, 32'h0);
  endtask

  task automatic t_stall_bubble();
    do_reset();
    fetch_pred_pc = 32'h20;
    @(negedge clk);
    set_later(4'h9, 4'h1, 4'h1, 32'h0);
    fetch_pred_pc = 32'h77; fetch_icode = 4'h3; fetch_dst_e = 4'h1; fetch_dst_m = 4'h2;
    #1;
    chk(stall_f && bubble_d, "R2 ret in E", {stall_f, bubble_d}, 2'b11);
    @(negedge clk); #1;
    chk(fetch_pc == 32'h20, "R4 hold", fetch_pc, 32'h20);
    chk(d_icode == 4'h1 && d_dst_e == 4'hF && d_dst_m == 4'hF, "R5 bubble",
        {d_icode, d_dst_e, d_dst_m}, 12'h1FF);
    set_later(4'h1, 4'h9, 4'h1, 32'h0);
    #1;
    chk(stall_f && bubble_d, "R2 ret in M", {stall_f, bubble_d}, 2'b11);
    set_later(4'h1, 4'h1, 4'h1, 32'h0);
  endtask

  function automatic logic [3:0] prog(input logic [31:0] a);
    if (a == 32'h4) return 4'h9;
    return 4'h6;
  endfunction

  task automatic t_sequence();
    logic [31:0] log_pc [1:10];
    logic        log_st [1:10];
    logic [3:0]  dq;
    do_reset();
    for (int cyc = 1; cyc <= 10; cyc++) begin
      fetch_icode = prog(fetch_pc);
      fetch_pred_pc = fetch_pc + 1;
      fetch_dst_e = 4'hF; fetch_dst_m = 4'hF;
      #1;
      log_pc[cyc] = fetch_pc;
      log_st[cyc] = stall_f;
      if (cyc == 6)
        chk(d_icode == 4'h9 && stall_f, "R2 ret in D", {d_icode, 3'b0, stall_f}, 8'h91);
      dq = d_icode;
      @(posedge clk); #1;
      w_icode = m_icode; m_icode = e_icode; e_icode = dq;
      w_valm = (w_icode == 4'h9) ? 32'h40 : 32'h0BAD;
      @(negedge clk);
    end
    for (int c = 1; c <= 5; c++)
      chk(log_pc[c] == c - 1, "R9 straight", log_pc[c], c - 1);
    for (int c = 6; c <= 8; c++) begin
      chk(log_pc[c] == 32'h5, "R9 stalled pc", log_pc[c], 32'h5);
      chk(log_st[c] == 1'b1, "R9 stall", log_st[c], 1);
    end
    chk(log_pc[9] == 32'h40, "R9 target", log_pc[9], 32'h40);
    chk(log_st[9] == 1'b0, "R9 released", log_st[9], 0);
    chk(log_pc[10] == 32'h41, "R9 after target", log_pc[10], 32'h41);
    set_later(4'h1, 4'h1, 4'h1, 32'h0);
  endtask

  initial begin
    t_reset();
    t_load_path();
    t_stall_bubble();
    t_sequence();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule